// File: doc/BRIEF.md
# Cascadable Universal Interrupt Controller

This block collects 32 interrupt request lines, brings each one into the local clock domain, and decides per line whether a request is seen as a level or as an edge, and whether the active sense is high (rising) or low (falling). A request sets a pending bit that stays set until software writes a one to it. An enable bit per line gates the pending bit onto one of two outputs, critical or non-critical, chosen by a per-line routing bit.

Software reaches six registers over a plain single-cycle bus. Reads return data combinationally from the address. The registers are pending status, enable, routing, sense polarity, trigger mode and a read-only view of pending-and-enabled lines. Because the outputs are plain levels, one instance can feed another. The non-critical output of a child drives a level-sensitive input of a parent, so a second bank of lines shares the parent's outputs.

Top module: `uic_ctrl`

## Requirements
- R1: While reset is asserted, the status, enable, routing, polarity and trigger registers read 0, and both outputs are 0.
- R2: Input n is carried on port bit 31-n and occupies register bit 31-n, so input 0 is the MSB. A line that changes on the bus side of a clock edge reaches its status bit on the third rising edge after the change and not before. A polarity bit of 1 makes the line active high or rising, and 0 makes it active low or falling.
- R3: The trigger register holds one bit per line. A value of 1 means edge mode: the status bit is set only on a new transition into the active sense, and a held active input does not set it again after a clear. A value of 0 means level mode: the status bit is set every cycle the input is active, so a clear while the input is still active leaves the bit at 1.
- R4: A write to address 0 clears every status bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged. A set request in the same cycle wins over the clear.
- R5: Address 5 reads the status register AND the enable register. Writes to address 5 change no register.
- R6: The non-critical output is the OR of all status bits that are enabled and have routing bit 0. The critical output is the same OR taken over routing bit 1. Routing is at address 2, enable at address 1, polarity at address 3 and trigger at address 4.
- R7: With its enable bit at 0, a line can still set its status bit, but it drives neither output.
- R8: In a cascade, the parent's level-mode bit fed by a child's non-critical output is set again after a clear for as long as the child still has an enabled pending line. Once the child's bit has been cleared, clearing the parent's bit drops the parent's output.
- R9: Addresses 6 and 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 32 | Raw request lines, input n on bit 31-n |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_crit | output | 1 | Critical interrupt output |
| irq_noncrit | output | 1 | Non-critical interrupt output |

## Verification
Random polarity, trigger, enable and routing settings are paired with random input vectors and random clear masks. This separates lines that must re-set after a clear (level mode, active) from lines that must stay clear (edge mode, no new transition), and it exercises every mix of critical and non-critical routing. Directed cases then pin down other behaviour: the exact three-edge latency of one line; falling-edge detection; clears with zero data bits; writes to the read-only and unused addresses; and a two-instance cascade in which the parent is cleared before and after its child.

// File: rtl/uic_pkg.sv
package uic_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RS_PEND  = 3'd0,
    RS_ENA   = 3'd1,
    RS_ROUTE = 3'd2,
    RS_SENSE = 3'd3,
    RS_MODE  = 3'd4,
    RS_MPEND = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/uic_in_stage.sv
module uic_in_stage #(
  parameter int NUM_IN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_raw,
  input  logic [NUM_IN-1:0] pol,
  input  logic [NUM_IN-1:0] trig,
  output logic [NUM_IN-1:0] set_o,
  output logic [NUM_IN-1:0] edge_o
);
  // active when the synchronised sample equals the sense bit
  function automatic logic apply_sense(input logic smp, input logic sense);
    return ~(smp ^ sense);
  endfunction

  for (genvar i = 0; i < NUM_IN; i++) begin : g_line
    logic meta_q, sync_q, prev_q, act;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b1;
      end else begin
        meta_q <= irq_raw[i];
        sync_q <= meta_q;
        prev_q <= act;
      end
    end

    assign act       = apply_sense(sync_q, pol[i]);
    assign edge_o[i] = act & ~prev_q;
    assign set_o[i]  = trig[i] ? edge_o[i] : act;
  end
endmodule

// File: rtl/uic_regfile.sv
module uic_regfile
  import uic_pkg::*;
#(
  parameter int NUM_IN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NUM_IN-1:0] bus_wdata,
  input  logic [NUM_IN-1:0] set_i,
  output logic [NUM_IN-1:0] bus_rdata,
  output logic [NUM_IN-1:0] status_o,
  output logic [NUM_IN-1:0] enable_o,
  output logic [NUM_IN-1:0] crit_o,
  output logic [NUM_IN-1:0] pol_o,
  output logic [NUM_IN-1:0] trig_o
);
  function automatic logic wr_hit(input logic sel, input logic wr,
                                  input logic [ADDR_W-1:0] a, input reg_sel_e r);
    return sel && wr && (a == r);
  endfunction

  logic [NUM_IN-1:0] clr_mask;
  assign clr_mask = wr_hit(bus_sel, bus_wr, bus_addr, RS_PEND) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_o <= '0;
      enable_o <= '0;
      crit_o   <= '0;
      pol_o    <= '0;
      trig_o   <= '0;
    end else begin
      status_o <= (status_o & ~clr_mask) | set_i;
      if (wr_hit(bus_sel, bus_wr, bus_addr, RS_ENA))   enable_o <= bus_wdata;
      if (wr_hit(bus_sel, bus_wr, bus_addr, RS_ROUTE)) crit_o   <= bus_wdata;
      if (wr_hit(bus_sel, bus_wr, bus_addr, RS_SENSE)) pol_o    <= bus_wdata;
      if (wr_hit(bus_sel, bus_wr, bus_addr, RS_MODE))  trig_o   <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      RS_PEND:  bus_rdata = status_o;
      RS_ENA:   bus_rdata = enable_o;
      RS_ROUTE: bus_rdata = crit_o;
      RS_SENSE: bus_rdata = pol_o;
      RS_MODE:  bus_rdata = trig_o;
      RS_MPEND: bus_rdata = status_o & enable_o;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uic_irq_merge.sv
module uic_irq_merge #(
  parameter int NUM_IN = 32
) (
  input  logic [NUM_IN-1:0] status,
  input  logic [NUM_IN-1:0] enable,
  input  logic [NUM_IN-1:0] crit,
  output logic              irq_crit,
  output logic              irq_noncrit
);
  function automatic logic route_any(input logic [NUM_IN-1:0] st,
                                     input logic [NUM_IN-1:0] en,
                                     input logic [NUM_IN-1:0] cr,
                                     input logic want_crit);
    logic [NUM_IN-1:0] pick;
    pick = want_crit ? cr : ~cr;
    return |(st & en & pick);
  endfunction

  assign irq_crit    = route_any(status, enable, crit, 1'b1);
  assign irq_noncrit = route_any(status, enable, crit, 1'b0);
endmodule

// File: rtl/uic_ctrl.sv
module uic_ctrl
  import uic_pkg::*;
#(
  parameter int NUM_IN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NUM_IN-1:0] bus_wdata,
  output logic [NUM_IN-1:0] bus_rdata,
  output logic              irq_crit,
  output logic              irq_noncrit
);
  logic [NUM_IN-1:0] set_vec, edge_vec;
  logic [NUM_IN-1:0] status_w, enable_w, crit_w, pol_w, trig_w;

  uic_in_stage #(.NUM_IN(NUM_IN)) in_stage_i (
    .clk(clk), .rst_n(rst_n), .irq_raw(irq_in),
    .pol(pol_w), .trig(trig_w), .set_o(set_vec), .edge_o(edge_vec)
  );

  uic_regfile #(.NUM_IN(NUM_IN)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .set_i(set_vec),
    .bus_rdata(bus_rdata), .status_o(status_w), .enable_o(enable_w),
    .crit_o(crit_w), .pol_o(pol_w), .trig_o(trig_w)
  );

  uic_irq_merge #(.NUM_IN(NUM_IN)) merge_i (
    .status(status_w), .enable(enable_w), .crit(crit_w),
    .irq_crit(irq_crit), .irq_noncrit(irq_noncrit)
  );
endmodule

// File: rtl/uic_ctrl_chk.sv
module uic_ctrl_chk #(
  parameter int NUM_IN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [2:0]        bus_addr,
  input logic [NUM_IN-1:0] bus_wdata,
  input logic [NUM_IN-1:0] set_vec,
  input logic [NUM_IN-1:0] status,
  input logic [NUM_IN-1:0] enable,
  input logic [NUM_IN-1:0] crit,
  input logic [NUM_IN-1:0] pol,
  input logic [NUM_IN-1:0] trig,
  input logic              irq_crit,
  input logic              irq_noncrit
);
  logic clr_wr, ro_wr;
  assign clr_wr = bus_sel && bus_wr && (bus_addr == 3'd0);
  assign ro_wr  = bus_sel && bus_wr && (bus_addr >= 3'd5);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (status == '0 && enable == '0 && crit == '0 &&
                                pol == '0 && trig == '0 && !irq_crit && !irq_noncrit);
    end
  end

  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(set_vec)) == '0));

  a_r3_edge_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (trig == $past(trig)) |-> ((set_vec & trig & $past(set_vec)) == '0));

  a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((status & $past(bus_wdata) & ~$past(set_vec)) == '0));

  a_r4_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((~status & $past(status)) == '0));

  a_r5_readonly_write: assert property (@(posedge clk) disable iff (!rst_n)
    ro_wr |=> (enable == $past(enable) && crit == $past(crit) &&
               pol == $past(pol) && trig == $past(trig)));

  a_r6_crit_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_crit |-> ((status & enable & crit) != '0));

  a_r6_noncrit_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_noncrit |-> ((status & enable & ~crit) != '0));

  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> (!irq_crit && !irq_noncrit));
endmodule

bind uic_ctrl uic_ctrl_chk #(.NUM_IN(NUM_IN)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .set_vec(set_vec),
  .status(status_w), .enable(enable_w), .crit(crit_w), .pol(pol_w),
  .trig(trig_w), .irq_crit(irq_crit), .irq_noncrit(irq_noncrit)
);

// File: tb/uic_ctrl_tb.sv
module uic_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic [31:0] drv_p, drv_c, wdata, rd_p, rd_c, irq_p;
  logic [2:0] addr;
  logic wr, sel_p, sel_c;
  logic crit_p, nc_p, crit_c, nc_c;
  int n_checks = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  assign irq_p = {nc_c, drv_p[30:0]};

  uic_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_p), .bus_sel(sel_p), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd_p),
    .irq_crit(crit_p), .irq_noncrit(nc_p)
  );

  uic_ctrl child_i (
    .clk(clk), .rst_n(rst_n), .irq_in(drv_c), .bus_sel(sel_c), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd_c),
    .irq_crit(crit_c), .irq_noncrit(nc_c)
  );

  function automatic logic [31:0] active_of(input logic [31:0] v, input logic [31:0] s);
    return (v & s) | (~v & ~s);
  endfunction

  function automatic logic out_of(input logic [31:0] st, input logic [31:0] en,
                                  input logic [31:0] cr, input logic want);
    logic [31:0] m;
    m = st & en;
    if (want) return (m & cr) != 32'h0;
    return (m & ~cr) != 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_cy(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input bit to_child, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    sel_p = !to_child; sel_c = to_child; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel_p = 1'b0; sel_c = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input bit from_child, input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = from_child ? rd_c : rd_p;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] r, pol_m, trig_m, en_m, cr_m, st_m, act_old, act_new, clr, vin;
    sel_p = 0; sel_c = 0; wr = 0; addr = 0; wdata = 0; drv_p = 0; drv_c = 0;
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    wait_cy(2);
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      bus_read(0, 3'(a), r);
      check("R1 reset register", r, 32'h0);
    end
    check("R1 reset outputs", {30'h0, crit_p, nc_p}, 32'h0);
    @(negedge clk) rst_n = 1'b1;

    // base setup: active high, level, all pending cleared, both instances
    bus_write(0, 3'd3, 32'hFFFF_FFFF);
    bus_write(1, 3'd3, 32'hFFFF_FFFF);
    wait_cy(4);
    bus_write(0, 3'd0, 32'hFFFF_FFFF);
    bus_write(1, 3'd0, 32'hFFFF_FFFF);
    wait_cy(3);
    bus_read(0, 3'd0, r);
    check("R4 clear all", r, 32'h0);

    // R2 mapping and latency: input 5 -> bit 26
    @(negedge clk) drv_p[26] = 1'b1;
    wait_cy(2);
    bus_read(0, 3'd0, r);
    check("R2 not yet set after two edges", r, 32'h0);
    wait_cy(1);
    bus_read(0, 3'd0, r);
    check("R2 set on third edge at bit 31-5", r, 32'h0400_0000);

    // R3 level re-set: clear while input still high
    bus_write(0, 3'd0, 32'h0400_0000);
    wait_cy(1);
    bus_read(0, 3'd0, r);
    check("R3 level bit stays set after clear", r, 32'h0400_0000);
    @(negedge clk) drv_p[26] = 1'b0;
    wait_cy(4);
    bus_write(0, 3'd0, 32'h0400_0000);
    wait_cy(2);
    bus_read(0, 3'd0, r);
    check("R3 level bit clears once input idle", r, 32'h0);

    // R3 edge mode on input 7 -> bit 24
    bus_write(0, 3'd4, 32'h0100_0000);
    @(negedge clk) drv_p[24] = 1'b1;
    wait_cy(4);
    bus_read(0, 3'd0, r);
    check("R3 rising edge sets", r, 32'h0100_0000);
    bus_write(0, 3'd0, 32'h0100_0000);
    wait_cy(4);
    bus_read(0, 3'd0, r);
    check("R3 held edge input does not re-set", r, 32'h0);
    bus_write(0, 3'd3, 32'hFEFF_FFFF);
    wait_cy(4);
    bus_read(0, 3'd0, r);
    check("R3 sense change without transition", r, 32'h0);
    @(negedge clk) drv_p[24] = 1'b0;
    wait_cy(4);
    bus_read(0, 3'd0, r);
    check("R3 falling edge sets with sense 0", r, 32'h0100_0000);
    bus_write(0, 3'd3, 32'hFFFF_FFFF);
    bus_write(0, 3'd4, 32'h0);
    wait_cy(4);
    bus_write(0, 3'd0, 32'hFFFF_FFFF);
    wait_cy(2);

    // R4 write zero bits keeps, write one clears: input 9 -> bit 22 latched
    @(negedge clk) drv_p[22] = 1'b1;
    wait_cy(4);
    @(negedge clk) drv_p[22] = 1'b0;
    wait_cy(4);
    bus_write(0, 3'd0, 32'hFFBF_FFFF);
    bus_read(0, 3'd0, r);
    check("R4 zero bit leaves pending", r, 32'h0040_0000);
    bus_write(0, 3'd0, 32'h0040_0000);
    bus_read(0, 3'd0, r);
    check("R4 one bit clears pending", r, 32'h0);

    // R6/R7 routing on bit 22 (re-latch)
    @(negedge clk) drv_p[22] = 1'b1;
    wait_cy(4);
    @(negedge clk) drv_p[22] = 1'b0;
    wait_cy(4);
    check("R7 disabled line gives no output", {30'h0, crit_p, nc_p}, 32'h0);
    bus_write(0, 3'd1, 32'h0040_0000);
    check("R6 non-critical route", {30'h0, crit_p, nc_p}, 32'h1);
    bus_write(0, 3'd2, 32'h0040_0000);
    check("R6 critical route", {30'h0, crit_p, nc_p}, 32'h2);
    bus_read(0, 3'd5, r);
    check("R5 masked status", r, 32'h0040_0000);
    bus_write(0, 3'd1, 32'h0);
    bus_read(0, 3'd0, r);
    check("R7 status kept while disabled", r, 32'h0040_0000);
    bus_read(0, 3'd5, r);
    check("R5 masked status with enable 0", r, 32'h0);

    // R5 / R9 writes to read-only and unused addresses
    bus_write(0, 3'd5, 32'hFFFF_FFFF);
    bus_write(0, 3'd6, 32'hFFFF_FFFF);
    bus_write(0, 3'd7, 32'hFFFF_FFFF);
    bus_read(0, 3'd1, r); check("R5 R9 enable untouched", r, 32'h0);
    bus_read(0, 3'd2, r); check("R5 R9 routing untouched", r, 32'h0040_0000);
    bus_read(0, 3'd3, r); check("R5 R9 polarity untouched", r, 32'hFFFF_FFFF);
    bus_read(0, 3'd4, r); check("R5 R9 trigger untouched", r, 32'h0);
    bus_read(0, 3'd0, r); check("R5 R9 status untouched", r, 32'h0040_0000);
    bus_read(0, 3'd6, r); check("R9 address 6 reads 0", r, 32'h0);
    bus_read(0, 3'd7, r); check("R9 address 7 reads 0", r, 32'h0);
    bus_write(0, 3'd2, 32'h0);
    bus_write(0, 3'd0, 32'hFFFF_FFFF);

    // R8 cascade: child input 3 (bit 28) into parent input 0 (bit 31)
    bus_write(1, 3'd1, 32'h1000_0000);
    bus_write(0, 3'd1, 32'h8000_0000);
    @(negedge clk) drv_c[28] = 1'b1;
    wait_cy(8);
    check("R8 parent output from child", {31'h0, nc_p}, 32'h1);
    @(negedge clk) drv_c[28] = 1'b0;
    wait_cy(4);
    bus_write(0, 3'd0, 32'h8000_0000);
    wait_cy(1);
    bus_read(0, 3'd0, r);
    check("R8 parent bit re-set while child pending", r, 32'h8000_0000);
    bus_write(1, 3'd0, 32'h1000_0000);
    wait_cy(5);
    check("R8 child output dropped", {31'h0, nc_c}, 32'h0);
    check("R8 parent still latched", {31'h0, nc_p}, 32'h1);
    bus_write(0, 3'd0, 32'h8000_0000);
    wait_cy(1);
    bus_read(0, 3'd0, r);
    check("R8 parent bit clears after child", r, 32'h0);
    check("R8 parent output drops", {31'h0, nc_p}, 32'h0);
    bus_write(0, 3'd1, 32'h0);

    // random phase: input 0 is held by the quiet child (0)
    void'($urandom(32'd1234));
    for (int it = 0; it < 40; it++) begin
      if (it % 10 == 0) begin
        pol_m = $urandom; trig_m = $urandom; en_m = $urandom; cr_m = $urandom;
        bus_write(0, 3'd3, pol_m);
        bus_write(0, 3'd4, trig_m);
        bus_write(0, 3'd1, en_m);
        bus_write(0, 3'd2, cr_m);
        wait_cy(5);
        bus_write(0, 3'd0, 32'hFFFF_FFFF);
        wait_cy(3);
        vin = {1'b0, drv_p[30:0]};
        act_old = active_of(vin, pol_m);
        st_m = ~trig_m & act_old;
        bus_read(0, 3'd0, r);
        check("R3 level lines re-set after full clear", r, st_m);
      end
      @(negedge clk) drv_p = $urandom;
      wait_cy(5);
      vin = {1'b0, drv_p[30:0]};
      act_new = active_of(vin, pol_m);
      st_m = st_m | (~trig_m & act_new) | (trig_m & act_new & ~act_old);
      act_old = act_new;
      bus_read(0, 3'd0, r);
      check("R2 R3 random status", r, st_m);
      bus_read(0, 3'd5, r);
      check("R5 random masked status", r, st_m & en_m);
      check("R6 random outputs", {30'h0, crit_p, nc_p},
            {30'h0, out_of(st_m, en_m, cr_m, 1'b1), out_of(st_m, en_m, cr_m, 1'b0)});
      clr = $urandom;
      bus_write(0, 3'd0, clr);
      wait_cy(2);
      st_m = (st_m & ~clr) | (~trig_m & act_new);
      bus_read(0, 3'd0, r);
      check("R4 random clear mask", r, st_m);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule